// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a memory-mapped watchdog. Its up-counter advances on a slow timer-tick enable, either on every tick or through a power-of-two prescaler. Software loads a start value, reloads the counter by writing a new pattern to a trigger register, and arms or disarms the watchdog only with two-word key sequences. If the counter wraps past all ones while armed, the block drives a fixed-length reset pulse and disarms itself.

Every writable register sits behind a posted-write slot. A write is captured at once, but it takes effect only after a fixed number of timer ticks. Until then a per-register busy bit reads 1, and any further write to that register is discarded. Control and load writes that take effect while the counter runs change nothing, so the timeout cannot be altered without first disarming.

Register word addresses on `addr`: 0 revision, 1 control, 2 load, 3 counter (read only), 4 trigger, 5 key, 6 write-pending status. Reads are registered and return data one clock after `addr` is presented.

Top module: `wdk_watchdog`

## Requirements
- R1: The counter starts running only after the key register (address 5) takes effect with 0xBBBB and then, as the next key word, 0x4444.
- R2: A running counter stops only after the key register takes effect with 0xAAAA and then, as the next key word, 0x5555. Any other word clears a partly entered sequence. A first key word (0xBBBB or 0xAAAA) is accepted in any state.
- R3: A trigger (address 4) value that differs from the last trigger value copies the load register into the counter. Repeating the last trigger value leaves the counter unchanged. The last trigger value is 0 after reset.
- R4: While running, the counter (address 3) rises by exactly one on each prescaled tick. While stopped, it holds its value.
- R5: Control (address 1) bit 5 enables the prescaler and bits 4:2 hold a ratio k. With the prescaler enabled, the counter advances once per 2^k timer ticks, counted from the moment it starts running. With it disabled, the counter advances on every tick. The control register reads back these bits.
- R6: Control and load writes that take effect while the counter runs change neither the register nor the counting.
- R7: The pending register (address 6) has one busy bit per register: bit 0 control, bit 2 load, bit 3 trigger, bit 4 key. A bit reads 1 from the write until PEND_TICKS timer ticks have passed. The write takes effect on the last of those ticks.
- R8: A write to a register whose busy bit is set is discarded.
- R9: When the counter advances from all ones while running, it wraps to 0 and stops, and `wdt_rst` is high for exactly RST_CYCLES clocks. A new start sequence re-arms the counter.
- R10: Bits 7:0 of the revision register (address 0) return the REV parameter and the upper bits read 0. After reset, the counter, control, load and pending registers read 0 and `wdt_rst` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow timer-tick enable, one clock wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address for reads and writes |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data for `addr` |
| wdt_rst | output | 1 | Reset pulse on counter overflow |

## Verification
A wrong key-sequence state shows within one tick of the second key word: the counter either moves when it must hold or holds when it must move. Prescaler errors appear as a wrong counter delta over a fixed window of ticks, and the bench sweeps all eight ratios in both enable modes. A stuck or early busy bit shows in the pending register on the first read after a write, or as a dropped or duplicated register value once the slot drains. A wrong overflow path shows within one clock of the wrap, in the width of the `wdt_rst` pulse or in a counter that keeps running.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_REV   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOAD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd3;
  localparam logic [ADDR_W-1:0] A_TRIG  = 3'd4;
  localparam logic [ADDR_W-1:0] A_KEY   = 3'd5;
  localparam logic [ADDR_W-1:0] A_PEND  = 3'd6;

  localparam logic [15:0] KEY_GO1   = 16'hBBBB;
  localparam logic [15:0] KEY_GO2   = 16'h4444;
  localparam logic [15:0] KEY_HALT1 = 16'hAAAA;
  localparam logic [15:0] KEY_HALT2 = 16'h5555;

  localparam int NSLOT   = 4;
  localparam int SL_CTRL = 0;
  localparam int SL_LOAD = 1;
  localparam int SL_TRIG = 2;
  localparam int SL_KEY  = 3;

  typedef enum logic [1:0] {KS_IDLE, KS_GO1, KS_HALT1} ks_state_t;

  function automatic logic [ADDR_W-1:0] slot_addr(input int s);
    case (s)
      SL_CTRL: return A_CTRL;
      SL_LOAD: return A_LOAD;
      SL_TRIG: return A_TRIG;
      default: return A_KEY;
    endcase
  endfunction
endpackage

// File: rtl/wdk_posted.sv
module wdk_posted #(
  parameter int DW         = 32,
  parameter int PEND_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_req,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          apply,
  output logic [DW-1:0] data
);
  localparam int CW = $clog2(PEND_TICKS + 1);

  logic [CW-1:0] left;

  assign apply = busy && tick && (left == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      left <= '0;
      data <= '0;
    end else if (!busy && wr_req) begin
      busy <= 1'b1;
      left <= CW'(PEND_TICKS);
      data <= wdata;
    end else if (busy && tick) begin
      left <= left - CW'(1);
      if (left == CW'(1)) busy <= 1'b0;
    end
  end

  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_req) |=> $stable(data)); // R8
  AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(apply)); // R7
endmodule

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
  import wdk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          apply,
  input  logic [DW-1:0] word,
  input  logic          force_stop,
  output logic          run
);
  ks_state_t st;

  logic is_go1, is_go2, is_halt1, is_halt2;
  assign is_go1   = (word == DW'(KEY_GO1));
  assign is_go2   = (word == DW'(KEY_GO2));
  assign is_halt1 = (word == DW'(KEY_HALT1));
  assign is_halt2 = (word == DW'(KEY_HALT2));

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= KS_IDLE;
      run <= 1'b0;
    end else begin
      if (force_stop) run <= 1'b0;
      if (apply) begin
        if (is_go1) st <= KS_GO1;
        else if (is_halt1) st <= KS_HALT1;
        else if (is_go2 && st == KS_GO1) begin
          run <= 1'b1;
          st  <= KS_IDLE;
        end else if (is_halt2 && st == KS_HALT1) begin
          run <= 1'b0;
          st  <= KS_IDLE;
        end else st <= KS_IDLE;
      end
    end
  end

  AST_START_KEYED: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> $past(apply && is_go2 && st == KS_GO1)); // R1
  AST_STOP_KEYED: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |-> $past((apply && is_halt2 && st == KS_HALT1) || force_stop)); // R2
endmodule

// File: rtl/wdk_prescale.sv
module wdk_prescale #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               tick,
  input  logic               en,
  input  logic [RATIO_W-1:0] ratio,
  output logic               ctick
);
  localparam int DIVW = (1 << RATIO_W) - 1;

  logic [DIVW-1:0] div;
  logic [DIVW:0]   one_sh;
  logic [DIVW-1:0] lim;
  logic            wrap;

  assign one_sh = (DIVW+1)'(1) << ratio;
  assign lim    = DIVW'(one_sh - (DIVW+1)'(1));
  assign wrap   = (div == lim);
  assign ctick  = tick && run && (!en || wrap);

  always_ff @(posedge clk) begin
    if (rst || !run) div <= '0;
    else if (tick && en) div <= wrap ? '0 : div + DIVW'(1);
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (rst)
    (run && en) |-> (div <= lim)); // R5
endmodule

// File: rtl/wdk_watchdog.sv
module wdk_watchdog
  import wdk_pkg::*;
#(
  parameter int         DW         = 32,
  parameter int         PEND_TICKS = 2,
  parameter int         RST_CYCLES = 4,
  parameter int         RATIO_W    = 3,
  parameter logic [7:0] REV        = 8'h31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              wdt_rst
);
  localparam int PE_BIT = 2 + RATIO_W;
  localparam int RW     = $clog2(RST_CYCLES + 1);

  logic [NSLOT-1:0] busy;
  logic [NSLOT-1:0] ap;
  logic [DW-1:0]    pd [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    wdk_posted #(.DW(DW), .PEND_TICKS(PEND_TICKS)) u_slot (
      .clk   (clk),
      .rst   (rst),
      .tick  (tick),
      .wr_req(wr_en && (addr == slot_addr(s))),
      .wdata (wdata),
      .busy  (busy[s]),
      .apply (ap[s]),
      .data  (pd[s])
    );
  end

  logic               run;
  logic               ctick;
  logic               pre_en;
  logic [RATIO_W-1:0] ratio;
  logic [DW-1:0]      load_q;
  logic [DW-1:0]      cnt;
  logic [DW-1:0]      last_trig;
  logic [RW-1:0]      rst_left;
  logic               reload;
  logic               ovf;

  assign reload = ap[SL_TRIG] && (pd[SL_TRIG] != last_trig);
  assign ovf    = run && ctick && (&cnt) && !reload;

  wdk_keyseq #(.DW(DW)) u_keys (
    .clk       (clk),
    .rst       (rst),
    .apply     (ap[SL_KEY]),
    .word      (pd[SL_KEY]),
    .force_stop(ovf),
    .run       (run)
  );

  wdk_prescale #(.RATIO_W(RATIO_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick),
    .en   (pre_en),
    .ratio(ratio),
    .ctick(ctick)
  );

  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^{pd[SL_CTRL][DW-1:PE_BIT+1], pd[SL_CTRL][1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_en    <= 1'b0;
      ratio     <= '0;
      load_q    <= '0;
      cnt       <= '0;
      last_trig <= '0;
      rst_left  <= '0;
      wdt_rst   <= 1'b0;
    end else begin
      if (ap[SL_CTRL] && !run) begin
        pre_en <= pd[SL_CTRL][PE_BIT];
        ratio  <= pd[SL_CTRL][PE_BIT-1:2];
      end
      if (ap[SL_LOAD] && !run) load_q <= pd[SL_LOAD];
      if (ap[SL_TRIG]) last_trig <= pd[SL_TRIG];
      if (reload) cnt <= load_q;
      else if (ctick) cnt <= cnt + DW'(1);
      if (ovf) rst_left <= RW'(RST_CYCLES);
      else if (rst_left != '0) rst_left <= rst_left - RW'(1);
      wdt_rst <= ovf || (rst_left > RW'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        A_REV:   rdata <= DW'(REV);
        A_CTRL:  rdata <= DW'({pre_en, ratio, 2'b00});
        A_LOAD:  rdata <= load_q;
        A_COUNT: rdata <= cnt;
        A_PEND:  rdata <= DW'({busy[SL_KEY], busy[SL_TRIG], busy[SL_LOAD], 1'b0, busy[SL_CTRL]});
        default: rdata <= '0;
      endcase
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> ($stable(load_q) && $stable(pre_en) && $stable(ratio))); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(ap[SL_TRIG])) |-> (cnt == $past(cnt) || ($past(run) && cnt == $past(cnt) + DW'(1)))); // R4
  AST_RST_DISARMS: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst) |-> (!run && cnt == '0)); // R9
endmodule

// File: tb/test_wdk_watchdog.sv
module test_wdk_watchdog;
  localparam int DW   = 32;
  localparam int PEND = 2;
  localparam int RSTC = 4;
  localparam logic [7:0] REVC = 8'h31;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    addr = 3'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          wdt_rst;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] trig_val = 32'd10;

  always #4 clk = ~clk;

  wdk_watchdog #(.DW(DW), .PEND_TICKS(PEND), .RST_CYCLES(RSTC), .RATIO_W(3), .REV(REVC)) i_wdk_watchdog (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wdt_rst(wdt_rst)
  );

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] v);
    @(negedge clk); addr = a;
    @(negedge clk); v = rdata;
  endtask

  task automatic wrf(input logic [2:0] a, input logic [DW-1:0] d);
    wr(a, d);
    tk(PEND);
  endtask

  task automatic start_seq;
    wrf(3'd5, 32'hBBBB);
    wrf(3'd5, 32'h4444);
  endtask

  task automatic stop_seq;
    wrf(3'd5, 32'hAAAA);
    wrf(3'd5, 32'h5555);
  endtask

  task automatic new_trig;
    trig_val = trig_val + 1;
    wrf(3'd4, trig_val);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [DW-1:0] v, c0, c1;
    int w;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state and revision
    chk({31'd0, wdt_rst}, 0, "R10 wdt_rst after reset");
    rd(3'd3, v); chk(v, 0, "R10 counter after reset");
    rd(3'd6, v); chk(v, 0, "R10 pending after reset");
    rd(3'd1, v); chk(v, 0, "R10 control after reset");
    rd(3'd2, v); chk(v, 0, "R10 load after reset");
    rd(3'd0, v); chk(v, {24'd0, REVC}, "R10 revision");

    // R7 pending window on load
    wr(3'd2, 32'h100);
    rd(3'd6, v); chk(v, 32'h04, "R7 load busy right after write");
    tk(1);
    rd(3'd6, v); chk(v, 32'h04, "R7 load busy after one tick");
    rd(3'd2, v); chk(v, 0, "R7 load not yet applied");
    tk(1);
    rd(3'd6, v); chk(v, 0, "R7 load busy cleared");
    rd(3'd2, v); chk(v, 32'h100, "R7 load applied");

    // R8 second write while busy is dropped
    wr(3'd2, 32'h200);
    wr(3'd2, 32'h300);
    tk(PEND);
    rd(3'd2, v); chk(v, 32'h200, "R8 busy write dropped");
    wr(3'd1, 32'h0);
    rd(3'd6, v); chk(v, 32'h01, "R7 control busy bit0");
    tk(PEND);

    // R3 trigger reload rules
    wr(3'd4, 32'h1);
    rd(3'd6, v); chk(v, 32'h08, "R7 trigger busy bit3");
    tk(PEND);
    rd(3'd3, v); chk(v, 32'h200, "R3 new trigger reloads");
    wrf(3'd2, 32'h500);
    wrf(3'd4, 32'h1);
    rd(3'd3, v); chk(v, 32'h200, "R3 repeated trigger no reload");
    wrf(3'd4, 32'h2);
    rd(3'd3, v); chk(v, 32'h500, "R3 changed trigger reloads");
    trig_val = 32'h2;

    // R1 broken start sequence
    wr(3'd5, 32'hBBBB);
    rd(3'd6, v); chk(v, 32'h10, "R7 key busy bit4");
    tk(PEND);
    wrf(3'd5, 32'h1234);
    wrf(3'd5, 32'h4444);
    tk(5);
    rd(3'd3, v); chk(v, 32'h500, "R1 broken sequence does not start");
    wrf(3'd5, 32'h4444);
    tk(3);
    rd(3'd3, v); chk(v, 32'h500, "R1 lone second key does not start");

    // R1 R4 proper start
    start_seq();
    rd(3'd3, c0); chk(c0, 32'h500, "R1 no count before start takes effect");
    tk(10);
    rd(3'd3, c1); chk(c1, c0 + 10, "R4 counts one per tick");

    // R2 interrupted stop, then first key in any state
    wrf(3'd5, 32'hAAAA);
    wrf(3'd5, 32'hBBBB);
    wrf(3'd5, 32'h5555);
    rd(3'd3, c0); tk(3);
    rd(3'd3, c1); chk(c1, c0 + 3, "R2 interrupted stop keeps running");
    wrf(3'd5, 32'hAAAA);
    wrf(3'd5, 32'h5555);
    rd(3'd3, c0); tk(4);
    rd(3'd3, c1); chk(c1, c0, "R2 stop sequence halts counter");

    // R6 config ignored while running
    start_seq();
    wrf(3'd2, 32'h777);
    wrf(3'd1, 32'h3C);
    rd(3'd3, c0); tk(8);
    rd(3'd3, c1); chk(c1, c0 + 8, "R6 control write ignored while running");
    stop_seq();
    rd(3'd2, v); chk(v, 32'h500, "R6 load write ignored while running");
    rd(3'd1, v); chk(v, 0, "R6 control unchanged");

    // R5 prescaler sweep
    for (int pe = 0; pe < 2; pe++) begin
      for (int r = 0; r < 8; r++) begin
        logic [DW-1:0] cw;
        cw = DW'((pe << 5) | (r << 2));
        wrf(3'd1, cw);
        rd(3'd1, v); chk(v, cw, "R5 control readback");
        new_trig();
        start_seq();
        rd(3'd3, c0);
        tk(300);
        rd(3'd3, c1);
        chk(c1 - c0, (pe != 0) ? DW'(300 >> r) : DW'(300), "R5 prescaled count");
        stop_seq();
      end
    end

    // R9 overflow
    wrf(3'd1, 32'h0);
    wrf(3'd2, 32'hFFFFFFF0);
    new_trig();
    start_seq();
    tk(15);
    rd(3'd3, v); chk(v, 32'hFFFFFFFF, "R9 counter at all ones");
    chk({31'd0, wdt_rst}, 0, "R9 no reset before wrap");
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    w = 0;
    while (wdt_rst === 1'b1) begin
      w++;
      @(negedge clk);
    end
    chk(DW'(w), DW'(RSTC), "R9 reset pulse width");
    rd(3'd3, v); chk(v, 0, "R9 counter wrapped to zero");
    tk(5);
    rd(3'd3, v); chk(v, 0, "R9 stopped after overflow");
    chk({31'd0, wdt_rst}, 0, "R9 reset released");
    start_seq();
    tk(3);
    rd(3'd3, v); chk(v, 3, "R9 re-armed by start sequence");

    report();
    $finish;
  end
endmodule